// File: doc/BRIEF.md
# Video Timing Divider Chain

This block turns the character-rate chain pulse into the slower timing references of a character video display. It is built as a cascade of five counters, all clocked by the master clock. The first counter steps once for each cycle in which the chain enable is high. Each later counter steps once each time the counter before it wraps.

The counters wrap at 4, 14, 12, 2 and 11. These are not powers of two, so each counter wraps by decoding its last value and going back to zero on the next step. Because the wrap is synchronous, there is never a brief extra count. With an 887.04 kHz chain rate, the chain gives a 15.840 kHz horizontal reference, a 1.32 kHz row reference and a 60 Hz field reference.

The two low bits of the first counter are brought out for video RAM addressing. Each rate reference is brought out as a one-cycle enable.

Top module: `vid_timing_divider`

## Requirements
- R1: While `rst_n` is low, every counter output is zero and every rate enable is low. After reset is released, counting starts again from zero.
- R2: In a cycle where `chain_en` is low, no counter output changes and no rate enable is asserted.
- R3: `ram_lo` is the count of chain enables modulo 4. It advances by one at each clock edge where `chain_en` is high.
- R4: `hcnt` counts wraps of the first counter and runs 0 through 13. `hrz_tick` is high exactly in the cycles where `chain_en` is high, `ram_lo` is 3 and `hcnt` is 13. This is one enable in 56.
- R5: `rcnt` counts `hrz_tick` pulses and runs 0 through 11. `row_tick` is high exactly in the cycles where `hrz_tick` is high and `rcnt` is 11. This is one enable in 672.
- R6: `par` changes value on every `row_tick`, which divides by 2.
- R7: `fcnt` counts wraps of `par` and runs 0 through 10. `field_tick` is high exactly in the cycles where `row_tick` is high, `par` is 1 and `fcnt` is 10. This is one enable in 14784.
- R8: Each rate enable lasts one cycle. At the clock edge that follows it, the stage it belongs to and every earlier stage read zero.
- R9: No counter ever holds a value equal to or larger than its modulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chain_en | input | 1 | Character chain rate enable |
| ram_lo | output | 2 | First counter, the low video RAM address bits |
| hcnt | output | 4 | Divide-by-14 counter |
| rcnt | output | 4 | Divide-by-12 counter |
| par | output | 1 | Divide-by-2 stage |
| fcnt | output | 4 | Divide-by-11 counter |
| hrz_tick | output | 1 | Horizontal-rate enable |
| row_tick | output | 1 | Row-rate enable |
| field_tick | output | 1 | Field-rate enable |

## Verification
The wraps of all five counters can fall in the same cycle. At the last chain enable of a field, the horizontal, row and field enables must all rise together, and every counter must read zero at the next edge.

The bench reaches this point by running whole fields under several chain-enable patterns:
- enable high every cycle;
- enable high one cycle in six;
- enable high two cycles in three.

For each pattern, the bench counts the enables it has applied. From that count it works out, using division and remainders, the value every output should have in every cycle.

// File: rtl/vtd_pkg.sv
package vtd_pkg;
    localparam int unsigned DEF_MOD_CHAR  = 4;
    localparam int unsigned DEF_MOD_HORIZ = 14;
    localparam int unsigned DEF_MOD_ROW   = 12;
    localparam int unsigned DEF_MOD_PAR   = 2;
    localparam int unsigned DEF_MOD_FIELD = 11;

    // Counter width needed to hold the values 0 .. mod-1.
    function automatic int unsigned stage_width(input int unsigned mod);
        return (mod > 1) ? $clog2(mod) : 1;
    endfunction
endpackage

// File: rtl/vtd_stage.sv
module vtd_stage
    import vtd_pkg::*;
#(
    parameter int unsigned MOD = 4,
    localparam int unsigned W  = stage_width(MOD)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    output logic [W-1:0] cnt,
    output logic         carry
);
    localparam logic [W-1:0] LAST = W'(MOD - 1);

    logic at_last;

    assign at_last = (cnt == LAST);
    assign carry   = en & at_last;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (en)
            cnt <= at_last ? '0 : cnt + W'(1);
    end

    assert_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(cnt));

    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !at_last) |=> (cnt == $past(cnt) + W'(1)));

    assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        carry |=> (cnt == '0));
endmodule

// File: rtl/vid_timing_divider.sv
module vid_timing_divider
    import vtd_pkg::*;
#(
    parameter int unsigned MOD_CHAR  = DEF_MOD_CHAR,
    parameter int unsigned MOD_HORIZ = DEF_MOD_HORIZ,
    parameter int unsigned MOD_ROW   = DEF_MOD_ROW,
    parameter int unsigned MOD_PAR   = DEF_MOD_PAR,
    parameter int unsigned MOD_FIELD = DEF_MOD_FIELD,
    localparam int unsigned WC = stage_width(MOD_CHAR),
    localparam int unsigned WH = stage_width(MOD_HORIZ),
    localparam int unsigned WR = stage_width(MOD_ROW),
    localparam int unsigned WP = stage_width(MOD_PAR),
    localparam int unsigned WF = stage_width(MOD_FIELD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chain_en,
    output logic [WC-1:0] ram_lo,
    output logic [WH-1:0] hcnt,
    output logic [WR-1:0] rcnt,
    output logic [WP-1:0] par,
    output logic [WF-1:0] fcnt,
    output logic          hrz_tick,
    output logic          row_tick,
    output logic          field_tick
);
    logic c_char, c_horiz, c_row, c_par, c_field;

    // Each stage is enabled by the carry of the stage before it.
    vtd_stage #(.MOD(MOD_CHAR))  u_char  (.clk(clk), .rst_n(rst_n), .en(chain_en), .cnt(ram_lo), .carry(c_char));
    vtd_stage #(.MOD(MOD_HORIZ)) u_horiz (.clk(clk), .rst_n(rst_n), .en(c_char),   .cnt(hcnt),   .carry(c_horiz));
    vtd_stage #(.MOD(MOD_ROW))   u_row   (.clk(clk), .rst_n(rst_n), .en(c_horiz),  .cnt(rcnt),   .carry(c_row));
    vtd_stage #(.MOD(MOD_PAR))   u_par   (.clk(clk), .rst_n(rst_n), .en(c_row),    .cnt(par),    .carry(c_par));
    vtd_stage #(.MOD(MOD_FIELD)) u_field (.clk(clk), .rst_n(rst_n), .en(c_par),    .cnt(fcnt),   .carry(c_field));

    assign hrz_tick   = c_horiz;
    assign row_tick   = c_row;
    assign field_tick = c_field;

    assert_row_nest_R5: assert property (@(posedge clk) disable iff (!rst_n)
        row_tick |-> hrz_tick);

    assert_field_nest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        field_tick |-> (row_tick && hrz_tick));

    assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_en |-> !hrz_tick);

    assert_field_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        field_tick |=> (ram_lo == '0 && hcnt == '0 && rcnt == '0 && par == '0 && fcnt == '0));

    assert_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hrz_tick |=> !hrz_tick);
endmodule

// File: tb/vid_timing_divider_test.sv
module vid_timing_divider_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chain_en = 1'b0;
    logic [1:0] ram_lo;
    logic [3:0] hcnt, rcnt, fcnt;
    logic [0:0] par;
    logic       hrz_tick, row_tick, field_tick;

    int checks = 0;
    int fails  = 0;
    longint n  = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vid_timing_divider uut (
        .clk(clk), .rst_n(rst_n), .chain_en(chain_en),
        .ram_lo(ram_lo), .hcnt(hcnt), .rcnt(rcnt), .par(par), .fcnt(fcnt),
        .hrz_tick(hrz_tick), .row_tick(row_tick), .field_tick(field_tick)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at enable %0d: actual %0d expected %0d", req, n, act, exp);
        end
    endtask

    // Check every output against the number of enables applied so far.
    task automatic check_state();
        chk("R3 ram_lo", ram_lo, n % 4);
        chk("R4 hcnt",   hcnt,   (n / 4) % 14);
        chk("R5 rcnt",   rcnt,   (n / 56) % 12);
        chk("R6 par",    par,    (n / 672) % 2);
        chk("R7 fcnt",   fcnt,   (n / 1344) % 11);
        chk("R4/R8 hrz_tick",   hrz_tick,   longint'(chain_en && (n % 56) == 55));
        chk("R5/R8 row_tick",   row_tick,   longint'(chain_en && (n % 672) == 671));
        chk("R7/R8 field_tick", field_tick, longint'(chain_en && (n % 14784) == 14783));
        chk("R9 range", longint'(ram_lo < 4 && hcnt < 14 && rcnt < 12 && fcnt < 11), 1);
    endtask

    // Drive one cycle at the falling edge, check, then count the rising edge.
    task automatic cycle(input bit en);
        @(negedge clk);
        chain_en = en;
        #1;
        check_state();
        if (!en) chk("R2 no tick when idle", longint'(hrz_tick | row_tick | field_tick), 0);
        @(posedge clk);
        if (en) n++;
    endtask

    task automatic run_pattern(input int period, input int on, input int cycles);
        for (int i = 0; i < cycles; i++) cycle((i % period) < on);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        chain_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        #1;
        chk("R1 reset counters", longint'({ram_lo, hcnt, rcnt, par, fcnt}), 0);
        chk("R1 reset ticks", longint'({hrz_tick, row_tick, field_tick}), 0);
        rst_n = 1'b1;
        chain_en = 1'b0;
        n = 0;
    endtask

    initial begin
        do_reset();
        // R3/R4/R8: every-cycle enable across a full field and past the R7 wrap
        run_pattern(1, 1, 14784 + 200);
        // R2: gaps of five idle cycles between enables, across a full field
        do_reset();
        run_pattern(6, 1, 14784 * 6 + 60);
        // Irregular pattern, then R1: reset in the middle of a field
        run_pattern(3, 2, 3000);
        do_reset();
        run_pattern(1, 1, 700);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule